// File: doc/BRIEF.md
# Card Host Interrupt Router

This block gathers the interrupt sources of a memory-card host controller into one register of sticky request flags. From those flags it produces a single processor interrupt line and two DMA request lines. Event pulses from the command path and the data path raise flags. Each flag falls when its owner clears it: a write-one-to-clear strobe, a FIFO access for the two FIFO service flags, or the clock-start control for the clock-off flag.

A 13-bit mask hides selected flags from the processor interrupt. A DMA-enable control takes the receive and transmit FIFO service flags away from the processor interrupt and drives them onto the DMA request lines instead. The clock start and stop controls keep a clock-enabled status bit, manage the clock-off flag and give a one-cycle abort pulse to the transfer logic.

Top module: `card_irq_router`

## Requirements
- R1: While reset is high and in the cycle after it falls, `pending`, `irq`, `dma_rx_req`, `dma_tx_req`, `clk_enabled` and `xfer_abort` are all 0. The mask and the DMA-enable control are also 0.
- R2: A 1 on `evt_set[i]` at a clock edge sets `pending[i]` at that edge. The flag then stays 1 until it is cleared. The positions are: 0 data done, 1 programming done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timer, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: A 1 on `req_clr[i]` clears `pending[i]` at that edge. If `evt_set[i]` is also 1 in the same cycle, the set wins.
- R4: `irq` is the OR of all pending flags that are not masked. It is registered, so it reflects the flags, mask and DMA enable one edge after they change.
- R5: When `mask_wr` is 1, `mask_wdata` replaces the whole mask. A mask bit of 1 keeps the flag at the same position out of `irq`.
- R6: When the DMA-enable control is 1, flags 5 and 6 are left out of `irq`. In that case `dma_rx_req` follows flag 5 and `dma_tx_req` follows flag 6, one edge later.
- R7: When the DMA-enable control is 0, `dma_rx_req` and `dma_tx_req` stay 0, whatever flags 5 and 6 hold.
- R8: `rx_fifo_rd` clears flag 5 and `tx_fifo_wr` clears flag 6. A same-cycle event on that flag wins.
- R9: `clk_start` sets `clk_enabled` and clears flag 4 at the edge. A same-cycle `evt_set[4]` still sets the flag.
- R10: `clk_stop` clears `clk_enabled` and sets flag 4 at the edge. It also raises `xfer_abort` for exactly one cycle. If `clk_start` and `clk_stop` arrive together, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr | input | 1 | Load strobe for the interrupt mask |
| mask_wdata | input | 13 | New mask value (1 = suppressed) |
| dma_en_wr | input | 1 | Load strobe for the DMA-enable control |
| dma_en_wdata | input | 1 | New DMA-enable value |
| clk_start | input | 1 | Clock-start control pulse |
| clk_stop | input | 1 | Clock-stop control pulse |
| evt_set | input | 13 | Event pulses, one per request flag |
| req_clr | input | 13 | Write-one-to-clear strobes for the request flags |
| rx_fifo_rd | input | 1 | Receive FIFO read strobe |
| tx_fifo_wr | input | 1 | Transmit FIFO write strobe |
| pending | output | 13 | Current request flags |
| irq | output | 1 | Processor interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| clk_enabled | output | 1 | Clock-enabled status |
| xfer_abort | output | 1 | One-cycle pulse that aborts the active transfer |

## Verification
Two pairs of actions can land on the same flag in the same cycle. One pair is a raising event together with a clear; the clear comes from the clear strobe, a FIFO access or the clock-start control. The other pair is clock start together with clock stop. The bench drives each such pair in the same cycle on purpose. At the same edge it checks that the flag is still 1, that `clk_enabled` is 0 and that `xfer_abort` pulsed. It then checks that `irq` and the DMA lines follow one edge later.

// File: rtl/cir_pkg.sv
`timescale 1ns/1ps
package cir_pkg;

    localparam int REQ_W       = 13;
    localparam int BIT_CLK_OFF = 4;
    localparam int BIT_RX_SVC  = 5;
    localparam int BIT_TX_SVC  = 6;

    typedef logic [REQ_W-1:0] req_vec_t;

    // Meaning of each request flag position
    typedef enum logic [3:0] {
        EV_DATA_DONE  = 4'd0,
        EV_PROG_DONE  = 4'd1,
        EV_CMD_END    = 4'd2,
        EV_STOP_CMD   = 4'd3,
        EV_CLK_OFF    = 4'd4,
        EV_RX_SVC     = 4'd5,
        EV_TX_SVC     = 4'd6,
        EV_TIMER      = 4'd7,
        EV_DATA_ERR   = 4'd8,
        EV_RESP_ERR   = 4'd9,
        EV_RD_STALL   = 4'd10,
        EV_CARD_INT   = 4'd11,
        EV_CARD_ACK   = 4'd12
    } req_id_e;

    // Per-cycle update applied to the flag register
    typedef struct packed {
        req_vec_t set;
        req_vec_t clr;
    } req_upd_t;

    // Registered routing result
    typedef struct packed {
        logic irq;
        logic dma_rx;
        logic dma_tx;
    } route_out_t;

    function automatic req_vec_t one_hot(input int pos);
        req_vec_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // Flags that move to the DMA lines when DMA is enabled
    function automatic req_vec_t svc_bits();
        return one_hot(BIT_RX_SVC) | one_hot(BIT_TX_SVC);
    endfunction

    // Set has priority over clear
    function automatic logic flag_next(input logic q, input logic s, input logic c);
        return s | (q & ~c);
    endfunction

endpackage

// File: rtl/cir_clk_ctrl.sv
`timescale 1ns/1ps
module cir_clk_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    output logic clk_en_o,
    output logic abort_o,
    output logic off_set_o,
    output logic off_clr_o
);

    logic clk_en_q;
    logic abort_q;

    // Stop is applied after start, so a simultaneous pair leaves the clock off
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            if (stop_i)
                clk_en_q <= 1'b0;
            else if (start_i)
                clk_en_q <= 1'b1;
            abort_q <= stop_i;
        end
    end

    assign clk_en_o  = clk_en_q;
    assign abort_o   = abort_q;
    assign off_set_o = stop_i;
    assign off_clr_o = start_i & ~stop_i;

endmodule

// File: rtl/cir_req_bank.sv
`timescale 1ns/1ps
module cir_req_bank
    import cir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_upd_t upd_i,
    output req_vec_t flags_o
);

    logic [REQ_W-1:0] flag_q;

    for (genvar gi = 0; gi < REQ_W; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[gi] <= 1'b0;
            else
                flag_q[gi] <= flag_next(flag_q[gi], upd_i.set[gi], upd_i.clr[gi]);
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/cir_route.sv
`timescale 1ns/1ps
module cir_route
    import cir_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  req_vec_t   flags_i,
    input  req_vec_t   mask_i,
    input  logic       dma_en_i,
    output route_out_t out_o
);

    req_vec_t   eff_mask;
    route_out_t out_d;
    route_out_t out_q;

    always_comb begin
        eff_mask     = mask_i | (dma_en_i ? svc_bits() : '0);
        out_d.irq    = |(flags_i & ~eff_mask);
        out_d.dma_rx = dma_en_i & flags_i[BIT_RX_SVC];
        out_d.dma_tx = dma_en_i & flags_i[BIT_TX_SVC];
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign out_o = out_q;

endmodule

// File: rtl/card_irq_router.sv
`timescale 1ns/1ps
module card_irq_router
    import cir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_wr,
    input  logic [REQ_W-1:0] mask_wdata,
    input  logic             dma_en_wr,
    input  logic             dma_en_wdata,
    input  logic             clk_start,
    input  logic             clk_stop,
    input  logic [REQ_W-1:0] evt_set,
    input  logic [REQ_W-1:0] req_clr,
    input  logic             rx_fifo_rd,
    input  logic             tx_fifo_wr,
    output logic [REQ_W-1:0] pending,
    output logic             irq,
    output logic             dma_rx_req,
    output logic             dma_tx_req,
    output logic             clk_enabled,
    output logic             xfer_abort
);

    req_vec_t   mask_q;
    logic       dma_en_q;
    logic       off_set;
    logic       off_clr;
    req_upd_t   upd;
    req_vec_t   flags;
    route_out_t route;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            dma_en_q <= 1'b0;
        end else begin
            if (mask_wr)
                mask_q <= mask_wdata;
            if (dma_en_wr)
                dma_en_q <= dma_en_wdata;
        end
    end

    cir_clk_ctrl u_clk (
        .clk       (clk),
        .rst       (rst),
        .start_i   (clk_start),
        .stop_i    (clk_stop),
        .clk_en_o  (clk_enabled),
        .abort_o   (xfer_abort),
        .off_set_o (off_set),
        .off_clr_o (off_clr)
    );

    // Merge every set and clear source into one update word
    always_comb begin
        upd.set = evt_set | (off_set ? one_hot(BIT_CLK_OFF) : '0);
        upd.clr = req_clr
                | (off_clr    ? one_hot(BIT_CLK_OFF) : '0)
                | (rx_fifo_rd ? one_hot(BIT_RX_SVC)  : '0)
                | (tx_fifo_wr ? one_hot(BIT_TX_SVC)  : '0);
    end

    cir_req_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .upd_i   (upd),
        .flags_o (flags)
    );

    cir_route u_route (
        .clk      (clk),
        .rst      (rst),
        .flags_i  (flags),
        .mask_i   (mask_q),
        .dma_en_i (dma_en_q),
        .out_o    (route)
    );

    assign pending    = flags;
    assign irq        = route.irq;
    assign dma_rx_req = route.dma_rx;
    assign dma_tx_req = route.dma_tx;

endmodule

// File: rtl/cir_checker.sv
`timescale 1ns/1ps
module cir_checker
    import cir_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REQ_W-1:0] evt_set,
    input logic [REQ_W-1:0] req_clr,
    input logic             rx_fifo_rd,
    input logic             clk_start,
    input logic             clk_stop,
    input logic [REQ_W-1:0] pending,
    input logic [REQ_W-1:0] mask_q,
    input logic             dma_en_q,
    input logic             irq,
    input logic             dma_rx_req,
    input logic             dma_tx_req,
    input logic             clk_enabled,
    input logic             xfer_abort
);

    AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> irq == |($past(pending) & ~($past(mask_q) | ($past(dma_en_q) ? svc_bits() : '0)))); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        pending[0] && !req_clr[0] |=> pending[0]); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_set[3] |=> pending[3]); // R3

    AST_DMA_RX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        dma_en_q && pending[BIT_RX_SVC] |=> dma_rx_req); // R6

    AST_DMA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dma_en_q |=> !dma_rx_req && !dma_tx_req); // R7

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_rd && !evt_set[BIT_RX_SVC] |=> !pending[BIT_RX_SVC]); // R8

    AST_CLK_START: assert property (@(posedge clk) disable iff (rst)
        clk_start && !clk_stop && !evt_set[BIT_CLK_OFF] |=> clk_enabled && !pending[BIT_CLK_OFF]); // R9

    AST_CLK_STOP: assert property (@(posedge clk) disable iff (rst)
        clk_stop |=> !clk_enabled && pending[BIT_CLK_OFF] && xfer_abort); // R10

    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_abort && !clk_stop |=> !xfer_abort); // R10

endmodule

bind card_irq_router cir_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .evt_set     (evt_set),
    .req_clr     (req_clr),
    .rx_fifo_rd  (rx_fifo_rd),
    .clk_start   (clk_start),
    .clk_stop    (clk_stop),
    .pending     (pending),
    .mask_q      (mask_q),
    .dma_en_q    (dma_en_q),
    .irq         (irq),
    .dma_rx_req  (dma_rx_req),
    .dma_tx_req  (dma_tx_req),
    .clk_enabled (clk_enabled),
    .xfer_abort  (xfer_abort)
);

// File: tb/card_irq_router_tb.sv
`timescale 1ns/1ps
module card_irq_router_tb_top;

    localparam int W = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mask_wr = 1'b0;
    logic [W-1:0] mask_wdata = '0;
    logic         dma_en_wr = 1'b0;
    logic         dma_en_wdata = 1'b0;
    logic         clk_start = 1'b0;
    logic         clk_stop = 1'b0;
    logic [W-1:0] evt_set = '0;
    logic [W-1:0] req_clr = '0;
    logic         rx_fifo_rd = 1'b0;
    logic         tx_fifo_wr = 1'b0;
    logic [W-1:0] pending;
    logic         irq, dma_rx_req, dma_tx_req, clk_enabled, xfer_abort;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    card_irq_router dut_i (
        .clk(clk), .rst(rst),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .dma_en_wr(dma_en_wr), .dma_en_wdata(dma_en_wdata),
        .clk_start(clk_start), .clk_stop(clk_stop),
        .evt_set(evt_set), .req_clr(req_clr),
        .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
        .pending(pending), .irq(irq),
        .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
        .clk_enabled(clk_enabled), .xfer_abort(xfer_abort)
    );

    typedef struct packed {
        logic [W-1:0] mask;
        logic         dma;
        logic [W-1:0] evt;
        logic         x_irq;
        logic         x_rx;
        logic         x_tx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{13'h0000, 1'b0, 13'h0001, 1'b1, 1'b0, 1'b0},
        '{13'h0001, 1'b0, 13'h0001, 1'b0, 1'b0, 1'b0},
        '{13'h1FFF, 1'b0, 13'h1FFF, 1'b0, 1'b0, 1'b0},
        '{13'h1FFE, 1'b0, 13'h1001, 1'b1, 1'b0, 1'b0},
        '{13'h0000, 1'b1, 13'h0020, 1'b0, 1'b1, 1'b0},
        '{13'h0000, 1'b1, 13'h0040, 1'b0, 1'b0, 1'b1},
        '{13'h0000, 1'b1, 13'h0060, 1'b0, 1'b1, 1'b1},
        '{13'h0000, 1'b0, 13'h0060, 1'b1, 1'b0, 1'b0},
        '{13'h0060, 1'b0, 13'h0060, 1'b0, 1'b0, 1'b0},
        '{13'h1F9F, 1'b1, 13'h0060, 1'b0, 1'b1, 1'b1},
        '{13'h0000, 1'b1, 13'h0800, 1'b1, 1'b0, 1'b0},
        '{13'h1000, 1'b0, 13'h1000, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mask_wr = 1'b0; dma_en_wr = 1'b0;
        clk_start = 1'b0; clk_stop = 1'b0;
        evt_set = '0; req_clr = '0;
        rx_fifo_rd = 1'b0; tx_fifo_wr = 1'b0;
    endtask

    // Clears every flag, loads mask and DMA enable, and raises evt in one cycle
    // (set wins over clear). Returns after the output edge has passed.
    task automatic load_case(input logic [W-1:0] m, input logic d, input logic [W-1:0] e);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = m;
        dma_en_wr = 1'b1; dma_en_wdata = d;
        req_clr = '1; evt_set = e;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "pending in reset", 32'(pending), 0);
        check("R1", "irq in reset", 32'(irq), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pending", 32'(pending), 0);
        check("R1", "outputs", {irq, dma_rx_req, dma_tx_req, clk_enabled, xfer_abort}, 0);

        // Table walk: R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            load_case(VECS[i].mask, VECS[i].dma, VECS[i].evt);
            check("R4/R5", $sformatf("vec%0d irq", i), 32'(irq), 32'(VECS[i].x_irq));
            check("R6/R7", $sformatf("vec%0d dma_rx", i), 32'(dma_rx_req), 32'(VECS[i].x_rx));
            check("R6/R7", $sformatf("vec%0d dma_tx", i), 32'(dma_tx_req), 32'(VECS[i].x_tx));
        end

        // R4 latency: flag at the event edge, irq one edge later
        load_case('0, 1'b0, '0);
        @(negedge clk); evt_set[2] = 1'b1;
        @(negedge clk); idle_inputs();
        check("R2", "pending[2] at event edge", 32'(pending[2]), 1);
        check("R4", "irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R4", "irq one edge later", 32'(irq), 1);

        // R2 sticky
        repeat (5) @(negedge clk);
        check("R2", "pending[2] held", 32'(pending[2]), 1);
        check("R2", "irq held", 32'(irq), 1);

        // R3 clear, then set beats clear
        req_clr[2] = 1'b1;
        @(negedge clk); idle_inputs();
        check("R3", "pending[2] cleared", 32'(pending[2]), 0);
        @(negedge clk);
        check("R3", "irq dropped", 32'(irq), 0);
        req_clr[3] = 1'b1; evt_set[3] = 1'b1;
        @(negedge clk); idle_inputs();
        check("R3", "set wins over clear", 32'(pending[3]), 1);

        // R8 FIFO accesses clear service flags
        load_case('0, 1'b1, 13'h0060);
        check("R6", "rx and tx requested", {dma_rx_req, dma_tx_req}, 2'b11);
        rx_fifo_rd = 1'b1;
        @(negedge clk); idle_inputs();
        check("R8", "rx flag cleared", 32'(pending[5]), 0);
        check("R8", "tx flag kept", 32'(pending[6]), 1);
        @(negedge clk);
        check("R8", "dma lines after rx read", {dma_rx_req, dma_tx_req}, 2'b01);
        tx_fifo_wr = 1'b1;
        @(negedge clk); idle_inputs();
        check("R8", "tx flag cleared", 32'(pending[6]), 0);
        @(negedge clk);
        check("R8", "dma_tx dropped", 32'(dma_tx_req), 0);
        rx_fifo_rd = 1'b1; evt_set[5] = 1'b1;
        @(negedge clk); idle_inputs();
        check("R8", "event wins over rx read", 32'(pending[5]), 1);

        // R9 / R10 clock controls
        load_case('0, 1'b0, '0);
        clk_start = 1'b1;
        @(negedge clk); idle_inputs();
        check("R9", "clk_enabled set", 32'(clk_enabled), 1);
        clk_stop = 1'b1;
        @(negedge clk); idle_inputs();
        check("R10", "clk_enabled cleared", 32'(clk_enabled), 0);
        check("R10", "clock-off flag set", 32'(pending[4]), 1);
        check("R10", "abort pulse", 32'(xfer_abort), 1);
        @(negedge clk);
        check("R10", "abort one cycle", 32'(xfer_abort), 0);
        check("R4", "irq from clock-off", 32'(irq), 1);
        clk_start = 1'b1;
        @(negedge clk); idle_inputs();
        check("R9", "clock-off flag cleared", 32'(pending[4]), 0);
        check("R9", "clk_enabled back", 32'(clk_enabled), 1);
        clk_start = 1'b1; clk_stop = 1'b1;
        @(negedge clk); idle_inputs();
        check("R10", "stop wins: clk_enabled", 32'(clk_enabled), 0);
        check("R10", "stop wins: flag", 32'(pending[4]), 1);
        check("R10", "stop wins: abort", 32'(xfer_abort), 1);

        // R1: reset again returns everything to zero
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pending after re-reset", 32'(pending), 0);
        check("R1", "outputs after re-reset", {irq, dma_rx_req, dma_tx_req, clk_enabled, xfer_abort}, 0);
        evt_set[5] = 1'b1;
        @(negedge clk); idle_inputs();
        @(negedge clk);
        check("R1", "irq sees cleared mask and dma", 32'(irq), 1);
        check("R7", "dma_rx low after reset", 32'(dma_rx_req), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule